// File: doc/BRIEF.md
# Retransmission Descriptor Manager

This block tracks the delivery state of a small window of outgoing data packets held in a transmit buffer. The buffer is divided into a fixed number of slots, one per packet of a "set". Each slot carries a set number plus three flags: filled and waiting to go out, transmitted at least once, and acknowledged by the far end. A data source fills slots in ring order. A frame transmitter asks for the next slot to send through a request/grant pair. Acknowledges from the receiver confirm slots. A slot that was granted but not yet confirmed is offered again on the next pass of the scan.

Three pointers move around the ring. The fill head marks the next slot to be loaded, and it waits at a slot that is still occupied. The scan pointer picks the slot offered to the transmitter. The tail frees confirmed slots in order: it clears each one and increments its set number, so the same slot can hold the same-index packet of the next set. Start and stop commands gate the transmitter side. When a granted slot had already been sent, a retransmit event pulse is produced, which a pacing controller can count.

Top module: `retx_desc_mgr`

## Requirements
- R1: After reset every slot is empty with set number 0 and all pointers are at slot 0, so `fill_ready_o`=1, `fill_idx_o`=0, `fill_set_o`=0, `tx_req_o`=0 and `retx_evt_o`=0.
- R2: `fill_i` while `fill_ready_o` is high loads the slot at `fill_idx_o` and moves the fill head to the next slot, wrapping from the last slot to 0.
- R3: `fill_ready_o` is low while the slot at the fill head is still occupied, and `fill_i` then has no effect.
- R4: `tx_req_o` is high only while transmission runs and the slot at the scan pointer is loaded and unconfirmed. The scan pointer visits slots in ascending order with wrap-around. It moves on after a grant or when its slot is not eligible, and it holds while stopped.
- R5: A grant (`tx_req_o` and `tx_gnt_i` both high at a clock edge) sets the slot's sent flag. `tx_retx_o` shows that flag for the offered slot. `retx_evt_o` is high for the one cycle after a grant of a slot that had already been sent.
- R6: A granted slot that is not acknowledged is offered again on a later pass, with `tx_retx_o`=1.
- R7: `ack_i` with `ack_idx_i` naming a loaded slot and `ack_set_i` equal to that slot's set number confirms the slot. A confirmed slot is never offered again.
- R8: An acknowledge whose set number differs from the slot's set number is ignored, and the slot stays eligible for transmission.
- R9: The tail moves one slot per cycle over confirmed slots in ring order, emptying each one and incrementing its set number. It stops at the first slot that is not confirmed, so a confirmed slot behind an unconfirmed one stays occupied.
- R10: `tx_req_o` is low in the cycle after `stop_i`. `start_i` resumes transmission, and `stop_i` wins when both are high.
- R11: A slot freed by the tail is reloaded with its incremented set number, which `fill_set_o` shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_i | input | 1 | Source has loaded the slot at the fill head |
| fill_ready_o | output | 1 | Slot at the fill head is free |
| fill_idx_o | output | IDX_W | Fill head slot index |
| fill_set_o | output | SET_W | Set number of the slot at the fill head |
| start_i | input | 1 | Start transmission command |
| stop_i | input | 1 | Stop transmission command |
| tx_req_o | output | 1 | A slot is offered to the transmitter |
| tx_gnt_i | input | 1 | Transmitter takes the offered slot |
| tx_idx_o | output | IDX_W | Offered slot index |
| tx_set_o | output | SET_W | Offered slot set number |
| tx_retx_o | output | 1 | Offered slot was sent before |
| ack_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | IDX_W | Acknowledged slot index |
| ack_set_i | input | SET_W | Acknowledged set number |
| retx_evt_o | output | 1 | One-cycle pulse after a retransmission grant |

## Verification
The bench confirms slots out of order, so the tail has to free two slots in order and then wait at an unconfirmed one. A design that freed slots as soon as each was acknowledged would raise `fill_ready_o` too early. It sends an acknowledge with the wrong set number and expects that slot to be retransmitted; a design that ignored the set compare would skip it. The fill head is wrapped past the last slot onto a slot freed earlier, and the incremented set number must appear there; a design that kept the old set would expose a stale tag. Stop is asserted while a request is pending, and while stopped with loaded slots, and no grant may happen in either case.

// File: rtl/desc_pkg.sv
package desc_pkg;
  typedef struct packed {
    logic valid;
    logic sent;
    logic conf;
  } slot_flags_t;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int DEPTH = 32,
  localparam int W = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] ptr_o
);
  logic [W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ptr_q <= '0;
    else if (adv_i) begin
      if (ptr_q == W'(DEPTH - 1))      ptr_q <= '0;
      else                             ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/run_ctl.sv
module run_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  output logic run_o
);
  logic run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (stop_i)  run_q <= 1'b0;
    else if (start_i) run_q <= 1'b1;
  end

  assign run_o = run_q;

  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_o); // R10
endmodule

// File: rtl/desc_slot.sv
module desc_slot
  import desc_pkg::*;
#(
  parameter int SET_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic             gnt_i,
  input  logic             ack_i,
  input  logic [SET_W-1:0] ack_set_i,
  input  logic             clr_i,
  output slot_flags_t      flags_o,
  output logic [SET_W-1:0] set_o
);
  slot_flags_t      flags_q;
  logic [SET_W-1:0] set_q;
  logic             ack_hit;

  assign ack_hit = ack_i && flags_q.valid && (ack_set_i == set_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      set_q   <= '0;
    end else if (clr_i) begin
      flags_q <= '0;
      set_q   <= set_q + 1'b1;
    end else begin
      if (fill_i) flags_q <= '{valid: 1'b1, sent: 1'b0, conf: 1'b0};
      if (gnt_i)   flags_q.sent <= 1'b1;
      if (ack_hit) flags_q.conf <= 1'b1;
    end
  end

  assign flags_o = flags_q;
  assign set_o   = set_q;

  AST_CONF_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q.conf |-> flags_q.valid); // R7
  AST_FILL_ONLY_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> !flags_q.valid); // R3
  AST_SET_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (set_q == SET_W'($past(set_q) + 1'b1)) && !flags_q.valid); // R9
  AST_STALE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_set_i != set_q && !flags_q.conf) |=> !flags_q.conf); // R8
endmodule

// File: rtl/retx_desc_mgr.sv
module retx_desc_mgr
  import desc_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SET_W     = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  output logic             fill_ready_o,
  output logic [IDX_W-1:0] fill_idx_o,
  output logic [SET_W-1:0] fill_set_o,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             tx_req_o,
  input  logic             tx_gnt_i,
  output logic [IDX_W-1:0] tx_idx_o,
  output logic [SET_W-1:0] tx_set_o,
  output logic             tx_retx_o,
  input  logic             ack_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  input  logic [SET_W-1:0] ack_set_i,
  output logic             retx_evt_o
);
  slot_flags_t      flags_w [NUM_SLOTS];
  logic [SET_W-1:0] set_w   [NUM_SLOTS];

  logic [IDX_W-1:0] head, scan, tail;
  logic             run;
  logic             fill_fire, gnt_fire, tail_clr, scan_ok, scan_adv;
  logic             retx_evt_q;

  run_ctl u_run (
    .clk_i, .rst_ni, .start_i, .stop_i, .run_o(run)
  );

  ring_ptr #(.DEPTH(NUM_SLOTS)) u_head (
    .clk_i, .rst_ni, .adv_i(fill_fire), .ptr_o(head)
  );
  ring_ptr #(.DEPTH(NUM_SLOTS)) u_scan (
    .clk_i, .rst_ni, .adv_i(scan_adv), .ptr_o(scan)
  );
  ring_ptr #(.DEPTH(NUM_SLOTS)) u_tail (
    .clk_i, .rst_ni, .adv_i(tail_clr), .ptr_o(tail)
  );

  assign fill_ready_o = !flags_w[head].valid;
  assign fill_fire    = fill_i && fill_ready_o;
  assign scan_ok      = flags_w[scan].valid && !flags_w[scan].conf;
  assign tx_req_o     = run && scan_ok;
  assign gnt_fire     = tx_req_o && tx_gnt_i;
  // scan freezes while stopped; otherwise it skips ineligible slots
  assign scan_adv     = run && (!scan_ok || tx_gnt_i);
  assign tail_clr     = flags_w[tail].valid && flags_w[tail].conf;

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(gi);
    desc_slot #(.SET_W(SET_W)) u_slot (
      .clk_i,
      .rst_ni,
      .fill_i   (fill_fire && head == SLOT),
      .gnt_i    (gnt_fire && scan == SLOT),
      .ack_i    (ack_i && ack_idx_i == SLOT),
      .ack_set_i(ack_set_i),
      .clr_i    (tail_clr && tail == SLOT),
      .flags_o  (flags_w[gi]),
      .set_o    (set_w[gi])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) retx_evt_q <= 1'b0;
    else         retx_evt_q <= gnt_fire && flags_w[scan].sent;
  end

  assign fill_idx_o = head;
  assign fill_set_o = set_w[head];
  assign tx_idx_o   = scan;
  assign tx_set_o   = set_w[scan];
  assign tx_retx_o  = flags_w[scan].sent;
  assign retx_evt_o = retx_evt_q;

  AST_STOP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !tx_req_o); // R10
  AST_RETX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retx_evt_o |-> $past(tx_gnt_i && tx_retx_o)); // R5
  AST_SCAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && !tx_gnt_i && !stop_i) |=> $stable(tx_idx_o)); // R4
  AST_GNT_MARKS_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && tx_gnt_i) |=> flags_w[$past(tx_idx_o)].sent); // R5
endmodule

// File: tb/retx_desc_mgr_bench.sv
module retx_desc_mgr_bench;
  localparam int NS = 32;
  localparam int SW = 8;
  localparam int IW = $clog2(NS);

  typedef struct packed {
    logic          any;
    logic [IW-1:0] idx;
    logic [SW-1:0] set;
    logic          retx;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fill = 0, start = 0, stop = 0, gnt = 0, ack = 0;
  logic [IW-1:0] ack_idx = '0;
  logic [SW-1:0] ack_set = '0;
  logic fill_ready, tx_req, tx_retx, retx_evt;
  logic [IW-1:0] fill_idx, tx_idx;
  logic [SW-1:0] fill_set, tx_set;

  int n_chk = 0, n_fail = 0, cyc = 0;
  exp_t exp_q[$];
  logic last_gnt = 0, last_retx = 0;

  always #2.5 clk = ~clk;

  retx_desc_mgr #(.NUM_SLOTS(NS), .SET_W(SW)) u_retx_desc_mgr (
    .clk_i(clk), .rst_ni(rst_n),
    .fill_i(fill), .fill_ready_o(fill_ready), .fill_idx_o(fill_idx), .fill_set_o(fill_set),
    .start_i(start), .stop_i(stop),
    .tx_req_o(tx_req), .tx_gnt_i(gnt), .tx_idx_o(tx_idx), .tx_set_o(tx_set), .tx_retx_o(tx_retx),
    .ack_i(ack), .ack_idx_i(ack_idx), .ack_set_i(ack_set),
    .retx_evt_o(retx_evt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: grants only what the scoreboard expects, then compares
  always @(negedge clk) begin
    if (last_gnt) chk("R5 retx_evt", int'(retx_evt), int'(last_retx));
    if (rst_n && tx_req && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      if (!e.any) chk("R4 tx_idx", int'(tx_idx), int'(e.idx));
      chk("R11 tx_set", int'(tx_set), int'(e.set));
      chk("R6 tx_retx", int'(tx_retx), int'(e.retx));
      gnt = 1'b1;
      last_gnt = 1'b1;
      last_retx = e.retx;
    end else begin
      gnt = 1'b0;
      last_gnt = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic push(input logic any, input int idx, input int set, input logic retx);
    exp_q.push_back('{any: any, idx: IW'(idx), set: SW'(set), retx: retx});
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_fill(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fill = 1'b1;
      @(negedge clk); fill = 1'b0;
    end
  endtask

  task automatic do_ack(input int idx, input int set);
    @(negedge clk); ack = 1'b1; ack_idx = IW'(idx); ack_set = SW'(set);
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fill_ready", int'(fill_ready), 1);
    chk("R1 fill_idx", int'(fill_idx), 0);
    chk("R1 fill_set", int'(fill_set), 0);
    chk("R1 tx_req", int'(tx_req), 0);
    chk("R1 retx_evt", int'(retx_evt), 0);

    // R2 fill four slots while stopped
    do_fill(4);
    chk("R2 fill_idx", int'(fill_idx), 4);
    chk("R10 no req while stopped", int'(tx_req), 0);

    // R4 R5 first pass in index order
    for (int i = 0; i < 4; i++) push(1'b0, i, 0, 1'b0);
    pulse_start();
    drain();

    // R7 confirm 1 then 0; R8 stale ack on slot 2
    do_ack(1, 0);
    do_ack(0, 0);
    do_ack(2, 5);
    // R6 slots 2 and 3 come back as retransmissions, 0 and 1 are skipped
    push(1'b0, 2, 0, 1'b1);
    push(1'b0, 3, 0, 1'b1);
    drain();

    // R10 stop, then load the rest while stopped
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R10 req after stop", int'(tx_req), 0);
    do_fill(NS - 4);
    // R2 wrap, R11 freed slot 0 carries set 1
    chk("R2 wrap fill_idx", int'(fill_idx), 0);
    chk("R11 fill_set", int'(fill_set), 1);
    do_fill(2);
    // R3 head waits at occupied slot 2
    chk("R3 fill_ready", int'(fill_ready), 0);
    chk("R3 fill_idx", int'(fill_idx), 2);
    do_fill(1);
    chk("R3 ignored fill", int'(fill_idx), 2);

    // R10 pending expectation must not be granted while stopped
    push(1'b1, 0, 0, 1'b0);
    repeat (8) @(negedge clk);
    chk("R10 no grant stopped", exp_q.size(), 1);
    pulse_start();
    drain();
    chk("R4 req pending", int'(tx_req), 1);
    @(negedge clk); stop = 1'b1; start = 1'b1;
    @(negedge clk); stop = 1'b0; start = 1'b0;
    chk("R10 stop immediate", int'(tx_req), 0);

    // R9 confirm 3 before 2: tail must wait at 2
    do_ack(3, 0);
    repeat (3) @(negedge clk);
    chk("R9 tail waits", int'(fill_ready), 0);
    do_ack(2, 0);
    repeat (3) @(negedge clk);
    chk("R9 tail frees", int'(fill_ready), 1);
    chk("R9 fill_idx", int'(fill_idx), 2);
    chk("R11 next set", int'(fill_set), 1);

    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule